// File: doc/BRIEF.md
# Bus Slave Front End with Strapped Address

This block is the two-wire serial slave interface of a hardware-monitor chip. It watches the clock and data lines and pulls data low through an open-drain enable. It answers only to its own 7-bit address. The upper five bits of that address are fixed. The lowest two bits are decoded from a three-state strap pin, which is read while reset is held.

A write transfer loads a register pointer from its first data byte. Every later byte in the same transfer goes to the pointed register as a single write pulse on a simple register port. A read transfer returns the byte at the current pointer, most significant bit first. To set the pointer before a read, the master sends a write with the pointer byte, then a repeated start and the read address.

If the clock line stays low for a set number of millisecond ticks, the interface drops back to idle and releases the data line. Register accesses work at any time, whatever the rest of the chip is doing.

Top module: `smb_strap_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0101100 with the two strap-derived bits in the lowest two places. It does not acknowledge any other address.
- R2: The strap input encodes 2'b00 as floating, 2'b01 as tied low and 2'b10 as tied high; 2'b11 is treated as floating. These give low address bits of 00, 10 and 01 respectively. The value 11 never occurs.
- R3: The strap is captured while reset is asserted. Changes to it after reset has been released have no effect on the recognised address.
- R4: The first data byte of a write transfer loads the register pointer (`reg_addr`) and raises no write pulse.
- R5: Each later data byte of a write transfer raises `reg_we` for exactly one clock, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The pointer does not change.
- R6: After a read address, the slave shifts out `reg_rdata` at the pointer, MSB first, changing the data line only while the clock is low. It sends the same register again after each master ACK and stops driving on a master NACK.
- R7: A STOP or START condition releases the data line (`sda_oe` low).
- R8: With SCL low, the TO_TICKS-th `ms_tick` (default 30, at most 35) returns the interface to idle and releases the data line. SCL high clears the count, and a fresh transfer is accepted afterwards.
- R9: While reset is asserted and just after it, `sda_oe` and `reg_we` are low, and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is sampled while it is low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired value) |
| sda_oe | output | 1 | High pulls the data line low |
| strap_pin | input | 2 | Three-state strap: 00 float, 01 low, 10 high |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data of the register at `reg_addr` |

## Verification
Both line inputs go through two synchroniser flops and one edge register. Every response to a clock edge therefore lands three clocks after the edge reaches the pins: the ACK drive, each read bit and the release all change three clocks after SCL falls, and `reg_we` rises three clocks after the eighth falling edge of a byte. The timeout release appears within two clocks of the terminal tick. The bench moves a line only a few clocks after the other one has settled. It samples the data line in the middle of the SCL high phase, and `sda_oe` several clocks after a tick or an edge, so each check falls well after its result is due. Write strobes are caught on falling clock edges by a monitor that compares them with a queue of expected pointer/data pairs.

// File: rtl/smb_strap_slave.sv
module smb_strap_slave #(
  parameter int          TO_TICKS = 30,
  parameter logic [4:0]  ADDR_TOP = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_pin,
  input  logic       ms_tick,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int TW = $clog2(TO_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  st_t          st;
  logic [2:0]   scl_p, sda_p;
  logic [3:0]   bcnt;
  logic [7:0]   sh;
  logic         rnw, first;
  logic [1:0]   addr_lo;
  logic [TW-1:0] tcnt;

  wire scl      = scl_p[1];
  wire sda      = sda_p[1];
  wire scl_rise = scl & ~scl_p[2];
  wire scl_fall = ~scl & scl_p[2];
  wire start_c  = scl & scl_p[2] & ~sda & sda_p[2];
  wire stop_c   = scl & scl_p[2] & sda & ~sda_p[2];
  wire timeout  = (tcnt == TO_TICKS[TW-1:0]);

  function automatic logic [1:0] strap_bits(input logic [1:0] s);
    case (s)
      2'b01:   return 2'b10;
      2'b10:   return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p     <= 3'b111;
      sda_p     <= 3'b111;
      st        <= S_IDLE;
      bcnt      <= '0;
      sh        <= '0;
      rnw       <= 1'b0;
      first     <= 1'b0;
      tcnt      <= '0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      addr_lo   <= strap_bits(strap_pin);
    end else begin
      scl_p  <= {scl_p[1:0], scl_i};
      sda_p  <= {sda_p[1:0], sda_i};
      reg_we <= 1'b0;

      if (scl)                      tcnt <= '0;
      else if (ms_tick && !timeout) tcnt <= tcnt + 1'b1;

      if (start_c) begin
        st     <= S_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c || timeout) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        case (st)
          S_ADDR, S_WR: begin
            sh   <= {sh[6:0], sda};
            bcnt <= bcnt + 4'd1;
          end
          S_RD:   bcnt <= bcnt + 4'd1;
          S_RACK: if (sda) st <= S_IDLE;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (bcnt == 4'd8) begin
            if (sh[7:1] == {ADDR_TOP, addr_lo}) begin
              st     <= S_AACK;
              sda_oe <= 1'b1;
              rnw    <= sh[0];
            end else begin
              st <= S_IDLE;
            end
          end
          S_AACK: begin
            bcnt <= '0;
            if (rnw) begin
              st     <= S_RD;
              sh     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
            end else begin
              st     <= S_WR;
              first  <= 1'b1;
              sda_oe <= 1'b0;
            end
          end
          S_WR: if (bcnt == 4'd8) begin
            st     <= S_WACK;
            sda_oe <= 1'b1;
            if (first) reg_addr <= sh;
            else begin
              reg_we    <= 1'b1;
              reg_wdata <= sh;
            end
          end
          S_WACK: begin
            st     <= S_WR;
            sda_oe <= 1'b0;
            bcnt   <= '0;
            first  <= 1'b0;
          end
          S_RD: if (bcnt == 4'd8) begin
            st     <= S_RACK;
            sda_oe <= 1'b0;
          end else begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
          S_RACK: begin
            st     <= S_RD;
            bcnt   <= '0;
            sh     <= reg_rdata;
            sda_oe <= ~reg_rdata[7];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk #(
  parameter int TO_TICKS = 30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       ms_tick,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [1:0] addr_lo
);
  logic [7:0] lowcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || scl_i)                lowcnt <= '0;
    else if (ms_tick && lowcnt != 8'hFF) lowcnt <= lowcnt + 8'd1;
  end

  assert_quiet_after_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !reg_we));

  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_drive_while_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lowcnt >= 8'(TO_TICKS + 2)) |-> !sda_oe);

  assert_strap_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(addr_lo));
endmodule

bind smb_strap_slave smb_strap_slave_chk #(.TO_TICKS(TO_TICKS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .ms_tick (ms_tick),
  .sda_oe  (sda_oe),
  .reg_we  (reg_we),
  .addr_lo (addr_lo)
);

// File: tb/smb_strap_slave_bench.sv
module smb_strap_slave_bench;
  localparam int H  = 8;
  localparam int TO = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic ms_tick = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [15:0] exp_q [$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  wire sda = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always #10 clk = ~clk;

  smb_strap_slave #(.TO_TICKS(TO)) u_smb_strap_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda), .sda_oe(sda_oe),
    .strap_pin(strap), .ms_tick(ms_tick), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      mem[reg_addr] = reg_wdata;
      if (exp_q.size() == 0) chk("R4 unexpected write strobe", 1, 0);
      else chk("R5 write addr/data", {reg_addr, reg_wdata}, exp_q.pop_front());
    end
  end

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset(logic [1:0] s);
    rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
    wclk(5);
    chk("R9 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wclk(5);
    chk("R9 oe after reset", sda_oe, 0);
    chk("R9 we after reset", reg_we, 0);
    chk("R9 pointer after reset", reg_addr, 0);
  endtask

  task automatic bus_start;
    wclk(H/2); sda_m = 1'b1; wclk(H/2); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    wclk(H/2); sda_m = 1'b0; wclk(H/2); scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_bit(bit b);
    wclk(H/2); sda_m = b; wclk(H/2); scl_m = 1'b1; wclk(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    wclk(H/2); sda_m = 1'b1; wclk(H/2); scl_m = 1'b1; wclk(H/2);
    b = sda; wclk(H/2); scl_m = 1'b0;
  endtask

  task automatic send8(logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic send_byte(logic [7:0] d, output bit ack);
    bit b;
    send8(d); get_bit(b); ack = !b;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit ack_it);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(!ack_it);
  endtask

  task automatic tick(int n);
    repeat (n) begin ms_tick = 1'b1; wclk(1); ms_tick = 1'b0; wclk(3); end
  endtask

  task automatic probe(logic [6:0] a, bit exp_ack, string req);
    bit ack;
    bus_start; send_byte({a, 1'b0}, ack); bus_stop;
    chk(req, ack, exp_ack);
  endtask

  task automatic write_regs(logic [7:0] ptr, logic [7:0] d0, logic [7:0] d1);
    bit ack;
    bus_start;
    send_byte({7'h2C, 1'b0}, ack); chk("R1 write address ack", ack, 1);
    send_byte(ptr, ack);
    chk("R4 pointer loaded", reg_addr, ptr);
    exp_q.push_back({ptr, d0}); send_byte(d0, ack);
    exp_q.push_back({ptr, d1}); send_byte(d1, ack);
    chk("R5 pointer unchanged", reg_addr, ptr);
    bus_stop;
    chk("R7 released after stop", sda_oe, 0);
  endtask

  task automatic read_regs(logic [7:0] ptr, logic [7:0] exp);
    bit ack;
    logic [7:0] d;
    bus_start;
    send_byte({7'h2C, 1'b0}, ack);
    send_byte(ptr, ack);
    bus_start;
    send_byte({7'h2C, 1'b1}, ack); chk("R1 read address ack", ack, 1);
    read_byte(d, 1'b1); chk("R6 first read byte", d, exp);
    read_byte(d, 1'b0); chk("R6 repeated read byte", d, exp);
    wclk(H);
    chk("R6 released after nack", sda_oe, 0);
    bus_stop;
    chk("R7 idle after read stop", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

    do_reset(2'b00);
    probe(7'h2C, 1, "R1 own address floating strap");
    probe(7'h2D, 0, "R1 foreign address 2D");
    probe(7'h2E, 0, "R1 foreign address 2E");
    probe(7'h2F, 0, "R2 address with low bits 11");
    probe(7'h6C, 0, "R1 upper bits differ");

    write_regs(8'h10, 8'h3C, 8'h5A);
    read_regs(8'h10, 8'h5A);
    read_regs(8'h42, 8'hE7);

    bus_start;
    send8({7'h2C, 1'b0});
    wclk(6);
    chk("R8 ack driven before timeout", sda_oe, 1);
    tick(TO - 1);
    chk("R8 held one tick short", sda_oe, 1);
    tick(1);
    wclk(2);
    chk("R8 released at timeout", sda_oe, 0);
    bus_stop;
    probe(7'h2C, 1, "R8 new transfer after timeout");

    bus_start;
    send_byte({7'h2C, 1'b0}, ack);
    send8(8'h20);
    wclk(6);
    tick(TO - 1);
    chk("R8 pointer ack still driven", sda_oe, 1);
    get_bit(ack);
    exp_q.push_back({8'h20, 8'h99});
    send8(8'h99);
    wclk(6);
    tick(TO - 1);
    chk("R8 count cleared by scl high", sda_oe, 1);
    get_bit(ack);
    bus_stop;
    chk("R8 data landed", mem[8'h20], 8'h99);

    do_reset(2'b01);
    probe(7'h2E, 1, "R2 tied low gives 10");
    probe(7'h2C, 0, "R2 tied low rejects 00");
    strap = 2'b10;
    wclk(4);
    probe(7'h2E, 1, "R3 strap change ignored");
    probe(7'h2D, 0, "R3 new strap not used");

    do_reset(2'b10);
    probe(7'h2D, 1, "R2 tied high gives 01");
    probe(7'h2E, 0, "R2 tied high rejects 10");

    do_reset(2'b11);
    probe(7'h2C, 1, "R2 code 11 acts as floating");
    probe(7'h2F, 0, "R2 low bits 11 never used");

    wclk(4);
    chk("R5 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule